// File: doc/BRIEF.md
# Command FIFO Sequencer Controller

This controller pulls 32-bit command words from a show-ahead command FIFO and carries them out one at a time. A command word with bit 31 set is a register write: the controller pulses a simple write port with a 7-bit address and 24 bits of data. A command word with bit 31 clear is a wait: the controller holds off the next fetch for a programmed number of clocks.

Software reaches three registers through a single-cycle port. The configuration register (address 0) holds the run enable, the empty-FIFO policy, a debug freeze and an 8-bit pacing value that spaces out register writes only. The command counter (address 1) counts finished commands. The status register (address 2) shows whether the controller stopped because it found the FIFO empty.

Top module: `cmdseq_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x00000002, the counter reads 0, the status reads 0, and neither fifo_rd nor wr_en is asserted.
- R2: Configuration bits 0 (enable), 1 (empty policy), 4 (freeze) and [15:8] (pacing) are writable. All other bits read as 0 whatever is written, so writing 0xFFFFFFFF reads back 0x0000FF13.
- R3: While enable is 0 the FIFO is never popped. While enable is 1 and the controller is free, fifo_rd pulses in any cycle the FIFO is not empty. fifo_rd is never asserted while fifo_empty is 1.
- R4: A command with bit 31 = 1 raises wr_en in the cycle it is popped, with wr_addr = bits [30:24] and wr_data = bits [23:0].
- R5: With pacing value N, the next pop comes N+1 cycles after the pop of a write command. N = 0 allows a write in every cycle.
- R6: A command with bit 31 = 0 and count C = bits [29:0] puts the next pop C+1 cycles after its own pop, whatever the pacing value. C = 0 behaves as a no-op.
- R7: While freeze is 1, no pop and no write occur and the remaining write or wait time is held. Clearing freeze resumes from the same point, so a wait delays its successor by C+1 plus the number of frozen cycles.
- R8: With policy 1, an attempted fetch from an empty FIFO stops the controller and sets status bit 0. No further pops occur, even after data arrives, until enable has been written 0 (which clears the status bit) and then 1.
- R9: With policy 0, an empty FIFO leaves status at 0 and the controller pops as soon as data arrives.
- R10: The 16-bit counter at address 1 increments by one when each command finishes: at the end of its write pacing or its wait, or in its pop cycle when that time is zero. Any write to address 1 clears it, and the clear wins over a completion in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select: 0 config, 1 counter, 2 status |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| fifo_empty | input | 1 | Command FIFO is empty |
| fifo_data | input | 32 | Head word of the command FIFO |
| fifo_rd | output | 1 | Pop the head word at this clock edge |
| wr_en | output | 1 | Register write strobe to the target |
| wr_addr | output | 7 | Target register address |
| wr_data | output | 24 | Target register data |

## Verification
The embedded properties guard, on every cycle, that no pop happens on an empty FIFO, while disabled, while frozen or after an underflow stop. They also check that the status bit rises only under the stop policy, that freeze holds the remaining time, that a paced write blocks the next pop and that the counter moves by at most one. The exact spacing of writes and waits, the length of delay a freeze adds, the restart sequence after an underflow stop and the counter values after runs of commands are shown only by the bench scenarios. In those scenarios a behavioural model predicts every output in every cycle.

// File: rtl/cmdseq_ctrl.sv
module cmdseq_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        fifo_empty,
  input  logic [31:0] fifo_data,
  output logic        fifo_rd,
  output logic        wr_en,
  output logic [6:0]  wr_addr,
  output logic [23:0] wr_data
);
  localparam logic [31:0] CFG_MASK  = 32'h0000_FF13;
  localparam logic [31:0] CFG_RESET = 32'h0000_0002;
  localparam int          TW        = 30;

  logic [31:0]    cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic           ustop_q;
  logic           busy_q;
  logic [TW-1:0]  left_q;

  wire en_q   = cfg_q[0];
  wire pol_q  = cfg_q[1];
  wire halt_q = cfg_q[4];
  wire [7:0] div_q = cfg_q[15:8];

  wire run     = en_q & ~ustop_q & ~halt_q;
  wire cfg_we  = reg_we && reg_addr == 2'd0;
  wire cnt_clr = reg_we && reg_addr == 2'd1;

  assign fifo_rd = run & ~busy_q & ~fifo_empty;
  assign wr_en   = fifo_rd & fifo_data[31];
  assign wr_addr = fifo_data[30:24];
  assign wr_data = fifo_data[23:0];

  wire [TW-1:0] span = fifo_data[31] ? {{(TW-8){1'b0}}, div_q} : fifo_data[TW-1:0];
  wire done = (fifo_rd && span == '0) || (run && busy_q && left_q == 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RESET;
      cnt_q   <= '0;
      ustop_q <= 1'b0;
      busy_q  <= 1'b0;
      left_q  <= '0;
    end else begin
      if (cfg_we) cfg_q <= reg_wdata & CFG_MASK;
      if (cnt_clr)   cnt_q <= '0;
      else if (done) cnt_q <= cnt_q + 1'b1;
      if (!en_q) begin
        busy_q  <= 1'b0;
        left_q  <= '0;
        ustop_q <= 1'b0;
      end else if (run) begin
        if (!busy_q) begin
          if (fifo_empty) begin
            if (pol_q) ustop_q <= 1'b1;
          end else if (span != '0) begin
            busy_q <= 1'b1;
            left_q <= span;
          end
        end else begin
          left_q <= left_q - 1'b1;
          if (left_q == 1) busy_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = cfg_q;
      2'd1:    reg_rdata = {{(32-CNT_W){1'b0}}, cnt_q};
      2'd2:    reg_rdata = {31'd0, ustop_q};
      default: reg_rdata = '0;
    endcase
  end

  p_pop_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);
  p_idle_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !fifo_rd);
  p_freeze_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> (!fifo_rd && !wr_en));
  p_freeze_holds_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && en_q) |=> $stable(left_q));
  p_stop_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ustop_q |-> !fifo_rd);
  p_stop_only_policy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ustop_q) |-> $past(pol_q));
  p_write_paced_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && div_q != 8'd0) |=> !fifo_rd);
  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: tb/cmdseq_ctrl_test.sv
`timescale 1ns/1ps
module cmdseq_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic reg_we = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic fifo_empty;
  logic [31:0] fifo_data;
  logic fifo_rd, wr_en;
  logic [6:0] wr_addr;
  logic [23:0] wr_data;

  logic [31:0] fmem [0:255];
  int head = 0, tail = 0;
  assign fifo_empty = (head == tail);
  assign fifo_data  = fmem[head];

  cmdseq_ctrl uut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_rd(fifo_rd), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data));

  always #2 clk = ~clk;

  int vectors = 0, fails = 0, cyc = 0;
  int pop_cyc [0:255];
  int npop = 0;
  logic [6:0]  wl_addr [0:255];
  logic [23:0] wl_data [0:255];
  int nw = 0;

  bit m_en = 0, m_pol = 1, m_halt = 0, m_ustop = 0, m_busy = 0;
  int m_div = 0, m_left = 0, m_cnt = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic [31:0] w;
    int n;
    bit dn;
    dn = 0;
    if (!rst_n) begin
      m_en = 0; m_pol = 1; m_halt = 0; m_ustop = 0; m_busy = 0;
      m_div = 0; m_left = 0; m_cnt = 0;
    end else begin
      cyc++;
      if (wr_en) begin wl_addr[nw] = wr_addr; wl_data[nw] = wr_data; nw++; end
      if (!m_en) begin
        m_busy = 0; m_left = 0; m_ustop = 0;
      end else if (!m_ustop && !m_halt) begin
        if (!m_busy) begin
          if (head == tail) begin
            if (m_pol) m_ustop = 1;
          end else begin
            w = fmem[head];
            n = w[31] ? m_div : int'(w[29:0]);
            pop_cyc[npop] = cyc; npop++;
            head++;
            if (n == 0) dn = 1;
            else begin m_busy = 1; m_left = n; end
          end
        end else begin
          if (m_left == 1) begin m_busy = 0; dn = 1; end
          m_left--;
        end
      end
      if (dn) m_cnt = (m_cnt + 1) & 16'hFFFF;
      if (reg_we) begin
        if (reg_addr == 2'd0) begin
          m_en = reg_wdata[0]; m_pol = reg_wdata[1]; m_halt = reg_wdata[4];
          m_div = int'(reg_wdata[15:8]);
        end else if (reg_addr == 2'd1) m_cnt = 0;
      end
      if (cyc > 20000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
    end
  end

  always @(negedge clk) begin
    bit e_rd, e_wr;
    logic [31:0] e_rdata;
    if (rst_n) begin
      e_rd = m_en && !m_ustop && !m_halt && !m_busy && (head != tail);
      e_wr = e_rd && fmem[head][31];
      check(fifo_rd == e_rd, "R3 fifo_rd", fifo_rd, e_rd);
      check(wr_en == e_wr, "R4 wr_en", wr_en, e_wr);
      if (e_wr) check({wr_addr, wr_data} == fmem[head][30:0], "R4 wr fields",
                      {wr_addr, wr_data}, fmem[head][30:0]);
      case (reg_addr)
        2'd0: e_rdata = {16'd0, 8'(m_div), 3'd0, m_halt, 2'd0, m_pol, m_en};
        2'd1: e_rdata = 32'(m_cnt);
        2'd2: e_rdata = {31'd0, m_ustop};
        default: e_rdata = 0;
      endcase
      check(reg_rdata == e_rdata, "R10 reg_rdata model", reg_rdata, e_rdata);
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] v);
    @(posedge clk); #1; reg_addr = a; reg_we = 1; reg_wdata = v;
    @(posedge clk); #1; reg_we = 0;
  endtask
  task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
    @(posedge clk); #1; reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic push(input logic [31:0] w);
    fmem[tail] = w; tail++;
  endtask

  initial begin
    logic [31:0] v;
    int k;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle(2);
    rd_reg(0, v); check(v == 32'h2, "R1 config reset", v, 32'h2);
    rd_reg(1, v); check(v == 0, "R1 counter reset", v, 0);
    rd_reg(2, v); check(v == 0, "R1 status reset", v, 0);
    idle(1);
    push(32'h8112_3456);
    idle(5); check(head == 0, "R3 no pop while disabled", head, 0);

    wr_reg(0, 32'hFFFF_FFFF);
    rd_reg(0, v); check(v == 32'h0000_FF13, "R2 reserved bits", v, 32'h0000_FF13);
    idle(4); check(head == 0, "R7 no pop while frozen", head, 0);
    wr_reg(0, 32'h1);
    idle(3);
    check(npop == 1, "R3 pop when enabled", npop, 1);
    check(wl_addr[0] == 7'h01, "R4 write address", wl_addr[0], 7'h01);
    check(wl_data[0] == 24'h123456, "R4 write data", wl_data[0], 24'h123456);

    k = npop;
    push(32'h8000_0001); push(32'h8200_0002); push(32'h8300_0003);
    idle(6);
    check(pop_cyc[k+1] - pop_cyc[k] == 1, "R5 pace 0 gap a", pop_cyc[k+1] - pop_cyc[k], 1);
    check(pop_cyc[k+2] - pop_cyc[k+1] == 1, "R5 pace 0 gap b", pop_cyc[k+2] - pop_cyc[k+1], 1);

    wr_reg(0, 32'h0301);
    k = npop;
    push(32'h8400_0004); push(32'h8500_0005); push(32'h8600_0006);
    idle(16);
    check(pop_cyc[k+1] - pop_cyc[k] == 4, "R5 pace 3 gap a", pop_cyc[k+1] - pop_cyc[k], 4);
    check(pop_cyc[k+2] - pop_cyc[k+1] == 4, "R5 pace 3 gap b", pop_cyc[k+2] - pop_cyc[k+1], 4);

    k = npop;
    push(32'h0000_0005); push(32'h8700_0007);
    idle(12);
    check(pop_cyc[k+1] - pop_cyc[k] == 6, "R6 wait 5 unpaced", pop_cyc[k+1] - pop_cyc[k], 6);
    k = npop;
    push(32'h0000_0000); push(32'h8800_0008);
    idle(6);
    check(pop_cyc[k+1] - pop_cyc[k] == 1, "R6 wait 0 no-op", pop_cyc[k+1] - pop_cyc[k], 1);

    wr_reg(0, 32'h1);
    k = npop;
    push(32'h0000_000A); push(32'h8900_0009);
    idle(2);
    wr_reg(0, 32'h11);
    idle(6);
    wr_reg(0, 32'h1);
    idle(25);
    check(pop_cyc[k+1] - pop_cyc[k] == 19, "R7 freeze extends wait", pop_cyc[k+1] - pop_cyc[k], 19);

    idle(10);
    rd_reg(2, v); check(v == 0, "R9 no stop with retry policy", v, 0);
    k = npop;
    idle(1); push(32'h8A00_000A);
    idle(3); check(npop == k + 1, "R9 pop on arrival", npop, k + 1);

    wr_reg(0, 32'h3);
    idle(3);
    rd_reg(2, v); check(v == 1, "R8 underflow stop flag", v, 1);
    k = npop;
    idle(1); push(32'h8B00_000B);
    idle(10); check(npop == k, "R8 no pop after stop", npop, k);
    wr_reg(0, 32'h2);
    idle(1);
    rd_reg(2, v); check(v == 0, "R8 flag cleared by disable", v, 0);
    wr_reg(0, 32'h3);
    idle(3); check(npop == k + 1, "R8 restart pops", npop, k + 1);

    rd_reg(1, v); check(v == 32'(tail), "R10 count of completed", v, tail);
    wr_reg(1, 32'h0);
    rd_reg(1, v); check(v == 0, "R10 counter clear", v, 0);
    wr_reg(0, 32'h0); wr_reg(0, 32'h1);
    push(32'h8C00_000C); push(32'h8D00_000D);
    idle(4);
    rd_reg(1, v); check(v == 2, "R10 count after clear", v, 2);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule